// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM array of 2^ROW_W rows alive. After reset it holds the strobes idle for a programmable power-up pause. It then runs a fixed number of refresh cycles, and only after that raises `init_done` and lets the access sequencer in. From then on a free-running interval timer raises refresh demands. A small pending counter keeps these demands, and each one is turned into a refresh cycle as soon as the strobes are free.

The block and the access sequencer share the DRAM strobes through a request/grant handshake. The sequencer holds `acc_req` and receives `acc_gnt` when the strobes are free. While `ref_own` is high, the strobes and the address driven by this block must reach the DRAM. The parameter `RAS_ONLY` picks the refresh style. With 0, the block issues CAS-before-RAS cycles and no address is needed. With 1, it issues row-addressed cycles with CAS held high, taking the row from an internal counter. Timing is set in clock cycles, so that at 125 MHz the defaults meet a 100 µs pause, a 15.6 µs spacing, a 64 ns RAS pulse and a 40 ns precharge.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, `ras_n`, `cas_n` and `we_n` are 1, and `init_done`, `acc_gnt`, `ref_own`, `addr_oe` and `ref_overflow` are 0.
- R2: No RAS strobe falls during the first PAUSE_CYC cycles after reset is released.
- R3: After the pause the block runs exactly INIT_CYCLES refresh cycles, all of the selected style, before `init_done` goes to 1. Once at 1, `init_done` stays at 1 until reset.
- R4: `acc_gnt` is never 1 while `init_done` is 0, and it is never 1 in a cycle where `ref_own` is 1.
- R5: With RAS_ONLY=0, `cas_n` is 0 for LEAD_CYC cycles before `ras_n` falls. It stays 0 while `ras_n` is 0 and returns to 1 in the same cycle as `ras_n`. `we_n` is 1 throughout, and `addr_oe` is 0.
- R6: Each RAS pulse is low for exactly RAS_CYC cycles. It is followed by at least PRE_CYC cycles with `ras_n` at 1 before the next fall.
- R7: With RAS_ONLY=1, `cas_n` stays 1 for the whole refresh. `addr_oe` is 1 from the start of the lead phase until RAS rises, so the row address is already driven in the cycle before RAS falls.
- R8: In RAS_ONLY=1 mode, `row_addr` is 0 for the first refresh after reset and goes up by one after each refresh, wrapping from 2^ROW_W-1 to 0.
- R9: After `init_done`, the interval timer runs freely. While no access holds the strobes, successive RAS falls are exactly INTERVAL_CYC cycles apart.
- R10: Unserved timer expiries are held in a pending count that saturates at two, and all of them are later served back to back. An expiry that arrives while two are already pending sets `ref_overflow`, which stays at 1 until reset.
- R11: When the block is idle, a pending refresh takes precedence over `acc_req`. With nothing pending, `acc_gnt` rises one cycle after `acc_req` is seen. It is held while `acc_req` stays at 1 and drops one cycle after `acc_req` falls. No refresh starts while the grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Access sequencer asks for the strobes |
| acc_gnt | output | 1 | Strobes granted to the access sequencer |
| init_done | output | 1 | Pause and initialization refreshes complete |
| ref_own | output | 1 | Refresh currently drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe for both byte lanes, active low |
| we_n | output | 1 | Write enable, held high by refresh |
| addr_oe | output | 1 | Refresh row address must be driven |
| row_addr | output | ROW_W | Refresh row address |
| ref_overflow | output | 1 | Sticky: a refresh demand was lost |

## Verification
The bench builds two copies of the block. Both use a 40-cycle pause, a 60-cycle interval, an 8-cycle RAS pulse, a 5-cycle precharge and a 1-cycle lead, so initialization and several intervals fit in a few hundred cycles. One copy uses CAS-before-RAS mode and is driven by the access handshake. Because its interval is short, a held grant can span three timer expiries, which reaches the saturated pending count and the overflow flag. The other copy uses row-addressed mode with ROW_W=3, so the row counter wraps within the initialization refreshes and the few that follow.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_LEAD,
    ST_RAS,
    ST_PRE,
    ST_ACC
  } ref_state_t;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL_CYC = 1950
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (run) begin
      if (cnt_q == TW'(INTERVAL_CYC - 1)) begin
        cnt_q <= '0;
        tick  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  // R9: the timer only expires while it has been released
  assert_tick_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(run));
endmodule

// File: rtl/refresh_pending_ctr.sv
module refresh_pending_ctr (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic take,
  output logic has_pend,
  output logic overflow
);
  logic [1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 2'd0;
      overflow <= 1'b0;
    end else begin
      case ({tick, take})
        2'b10: begin
          if (pend_q == 2'd2) overflow <= 1'b1;
          else                pend_q   <= pend_q + 2'd1;
        end
        2'b01:   pend_q <= pend_q - 2'd1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign has_pend = (pend_q != 2'd0);

  assert_pend_bounded_R10: assert property (@(posedge clk) disable iff (rst)
    pend_q <= 2'd2);
  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $past(overflow) |-> overflow);
  assert_no_take_empty_R10: assert property (@(posedge clk) disable iff (rst)
    take |-> has_pend);
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst)      row <= '0;
    else if (adv) row <= row + 1'b1;
  end

  // R8: the row only moves by one, wrapping naturally at the top
  assert_row_step_R8: assert property (@(posedge clk) disable iff (rst)
    (row != $past(row)) |-> (row == $past(row) + 1'b1));
endmodule

// File: rtl/refresh_strobe_fsm.sv
module refresh_strobe_fsm
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYC   = 12500,
  parameter int INIT_CYCLES = 8,
  parameter int LEAD_CYC    = 1,
  parameter int RAS_CYC     = 8,
  parameter int PRE_CYC     = 5,
  parameter bit RAS_ONLY    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_req,
  input  logic has_pend,
  output logic take,
  output logic adv,
  output logic init_done,
  output logic acc_gnt,
  output logic ref_own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic addr_oe
);
  localparam int M1 = (PAUSE_CYC > RAS_CYC) ? PAUSE_CYC : RAS_CYC;
  localparam int M2 = (PRE_CYC > LEAD_CYC) ? PRE_CYC : LEAD_CYC;
  localparam int MX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MX + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  ref_state_t    st_q, st_nxt;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] init_cnt_q;
  logic          lead_end, ras_end, pre_end, cas_lo_nxt, oe_nxt;

  assign lead_end = (cnt_q == CW'(LEAD_CYC - 1));
  assign ras_end  = (cnt_q == CW'(RAS_CYC - 1));
  assign pre_end  = (cnt_q == CW'(PRE_CYC - 1));

  always_comb begin
    st_nxt = st_q;
    take   = 1'b0;
    adv    = 1'b0;
    case (st_q)
      ST_PAUSE: if (cnt_q == CW'(PAUSE_CYC - 1)) st_nxt = ST_LEAD;
      ST_IDLE: begin
        if (!init_done) st_nxt = ST_LEAD;
        else if (has_pend) begin
          st_nxt = ST_LEAD;
          take   = 1'b1;
        end else if (acc_req) st_nxt = ST_ACC;
      end
      ST_LEAD: if (lead_end) st_nxt = ST_RAS;
      ST_RAS:  if (ras_end)  st_nxt = ST_PRE;
      ST_PRE: if (pre_end) begin
        st_nxt = ST_IDLE;
        adv    = 1'b1;
      end
      ST_ACC:  if (!acc_req) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  // Mode-specific strobe decode
  generate
    if (RAS_ONLY) begin : g_row_mode
      assign cas_lo_nxt = 1'b0;
      assign oe_nxt     = (st_nxt == ST_LEAD) || (st_nxt == ST_RAS);
    end else begin : g_cbr_mode
      assign cas_lo_nxt = (st_nxt == ST_LEAD) || (st_nxt == ST_RAS);
      assign oe_nxt     = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_PAUSE;
      cnt_q      <= '0;
      init_cnt_q <= '0;
      init_done  <= 1'b0;
      ras_n      <= 1'b1;
      cas_n      <= 1'b1;
      we_n       <= 1'b1;
      addr_oe    <= 1'b0;
      ref_own    <= 1'b0;
      acc_gnt    <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      cnt_q <= (st_nxt != st_q) ? '0 : cnt_q + 1'b1;
      if (adv && !init_done) begin
        init_cnt_q <= init_cnt_q + 1'b1;
        if (init_cnt_q == IW'(INIT_CYCLES - 1)) init_done <= 1'b1;
      end
      ras_n   <= (st_nxt != ST_RAS);
      cas_n   <= !cas_lo_nxt;
      we_n    <= 1'b1;
      addr_oe <= oe_nxt;
      ref_own <= (st_nxt == ST_LEAD) || (st_nxt == ST_RAS) || (st_nxt == ST_PRE);
      acc_gnt <= (st_nxt == ST_ACC);
    end
  end

  assert_gnt_after_init_R4: assert property (@(posedge clk) disable iff (rst)
    acc_gnt |-> init_done);
  assert_gnt_own_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(acc_gnt && ref_own));
  assert_init_stays_R3: assert property (@(posedge clk) disable iff (rst)
    !$fell(init_done));
  assert_ras_owned_R6: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> ref_own);
  generate
    if (RAS_ONLY) begin : g_row_chk
      assert_row_cas_high_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (cas_n && addr_oe && $past(addr_oe)));
    end else begin : g_cbr_chk
      assert_cbr_order_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n) && we_n && !addr_oe));
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PAUSE_CYC    = 12500,
  parameter int INTERVAL_CYC = 1950,
  parameter int INIT_CYCLES  = 8,
  parameter int LEAD_CYC     = 1,
  parameter int RAS_CYC      = 8,
  parameter int PRE_CYC      = 5,
  parameter int ROW_W        = 10,
  parameter bit RAS_ONLY     = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_req,
  output logic             acc_gnt,
  output logic             init_done,
  output logic             ref_own,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             addr_oe,
  output logic [ROW_W-1:0] row_addr,
  output logic             ref_overflow
);
  logic tick, take, adv, has_pend;

  refresh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(init_done), .tick(tick)
  );

  refresh_pending_ctr u_pend (
    .clk(clk), .rst(rst), .tick(tick), .take(take),
    .has_pend(has_pend), .overflow(ref_overflow)
  );

  refresh_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .adv(adv), .row(row_addr)
  );

  refresh_strobe_fsm #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_CYCLES(INIT_CYCLES), .LEAD_CYC(LEAD_CYC),
    .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC), .RAS_ONLY(RAS_ONLY)
  ) u_fsm (
    .clk(clk), .rst(rst), .acc_req(acc_req), .has_pend(has_pend),
    .take(take), .adv(adv), .init_done(init_done), .acc_gnt(acc_gnt),
    .ref_own(ref_own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr_oe(addr_oe)
  );
endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int PAUSE = 40;
  localparam int INTV  = 60;
  localparam int INIT  = 8;
  localparam int LEAD  = 1;
  localparam int RASC  = 8;
  localparam int PREC  = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, acc_req, b_req;
  logic a_gnt, a_init, a_own, a_ras, a_cas, a_we, a_oe, a_ovf;
  logic [9:0] a_row;
  logic b_gnt, b_init, b_own, b_ras, b_cas, b_we, b_oe, b_ovf;
  logic [2:0] b_row;

  dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .INIT_CYCLES(INIT),
    .LEAD_CYC(LEAD), .RAS_CYC(RASC), .PRE_CYC(PREC), .ROW_W(10), .RAS_ONLY(1'b0))
  u_dram_refresh_sched (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_gnt(a_gnt), .init_done(a_init),
    .ref_own(a_own), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we), .addr_oe(a_oe),
    .row_addr(a_row), .ref_overflow(a_ovf));

  dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .INIT_CYCLES(INIT),
    .LEAD_CYC(LEAD), .RAS_CYC(RASC), .PRE_CYC(PREC), .ROW_W(3), .RAS_ONLY(1'b1))
  u_dram_refresh_sched_ro (
    .clk(clk), .rst(rst), .acc_req(b_req), .acc_gnt(b_gnt), .init_done(b_init),
    .ref_own(b_own), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we), .addr_oe(b_oe),
    .row_addr(b_row), .ref_overflow(b_ovf));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Driver side of the scoreboard: expected refresh rows, wrapping at 8
  logic [2:0] exp_q[$];
  task automatic push_rows(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(3'(i));
  endtask

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // Monitor for the CAS-before-RAS copy
  logic pa_ras = 1'b1, pa_cas = 1'b1;
  int falls_a = 0, lo_a = 0, hi_a = 0, last_a = 0;
  bit init_seen = 0;
  always @(negedge clk) if (!rst) begin
    if (pa_ras && !a_ras) begin
      falls_a++;
      chk(!pa_cas, "R5 cas lead before ras fall", pa_cas, 0);
      chk(a_we && !a_oe, "R5 we_n high, addr_oe low", {a_we, a_oe}, 2);
      if (falls_a == 1) chk(cyc >= PAUSE, "R2 first ras fall after pause", cyc, PAUSE);
      if (falls_a > 1) chk(hi_a >= PREC, "R6 precharge length", hi_a, PREC);
      if (falls_a == 10 || falls_a == 11)
        chk(cyc - last_a == INTV, "R9 refresh spacing", cyc - last_a, INTV);
      last_a = cyc;
      lo_a = 1;
    end else if (!a_ras) begin
      lo_a++;
      chk(!a_cas, "R5 cas low during ras", a_cas, 0);
    end
    if (!pa_ras && a_ras) begin
      chk(lo_a == RASC, "R6 ras pulse width", lo_a, RASC);
      chk(a_cas, "R5 cas rises with ras", a_cas, 1);
      hi_a = 1;
    end else if (a_ras) hi_a++;
    if (a_init && !init_seen) begin
      init_seen = 1;
      chk(falls_a == INIT, "R3 init refresh count", falls_a, INIT);
    end
    if (init_seen && !a_init) chk(0, "R3 init_done dropped", 0, 1);
    if (a_gnt) begin
      chk(a_init, "R4 grant needs init_done", a_init, 1);
      chk(!a_own, "R4 grant while refresh owns", a_own, 0);
    end
    pa_ras = a_ras;
    pa_cas = a_cas;
  end

  // Monitor for the row-addressed copy: pops expected rows
  logic pb_ras = 1'b1, pb_oe = 1'b0;
  int falls_b = 0, lo_b = 0;
  always @(negedge clk) if (!rst) begin
    if (pb_ras && !b_ras) begin
      logic [2:0] e;
      falls_b++;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 3'd0;
      chk(b_row == e, "R8 refresh row", b_row, e);
      chk(b_cas && b_oe && pb_oe, "R7 cas high, address driven", {b_cas, b_oe, pb_oe}, 7);
      lo_b = 1;
    end else if (!b_ras) begin
      lo_b++;
      chk(b_cas, "R7 cas high during ras", b_cas, 1);
    end
    if (!pb_ras && b_ras) chk(lo_b == RASC, "R6 ras width row mode", lo_b, RASC);
    pb_ras = b_ras;
    pb_oe  = b_oe;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int f0, g;
    rst = 1'b1; acc_req = 1'b0; b_req = 1'b0;
    push_rows(40);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(a_ras && a_cas && a_we, "R1 strobes idle in reset", {a_ras, a_cas, a_we}, 7);
    chk(!a_init && !a_gnt && !a_own && !a_oe && !a_ovf, "R1 flags low in reset",
        {a_init, a_gnt, a_own, a_oe, a_ovf}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(a_ras && a_cas && !a_init && !a_own, "R1 state after reset",
        {a_ras, a_cas, a_init, a_own}, 12);
    chk(b_ras && b_cas && !b_oe, "R1 row copy idle", {b_ras, b_cas, b_oe}, 6);
    acc_req = 1'b1;
    repeat (PAUSE / 2) @(negedge clk);
    chk(a_ras && !a_gnt, "R2 quiet pause, no grant", {a_ras, a_gnt}, 2);
    acc_req = 1'b0;

    wait (falls_a == 11);
    do @(negedge clk); while (a_own);
    acc_req = 1'b1;
    @(negedge clk);
    chk(a_gnt, "R11 grant one cycle after request", a_gnt, 1);
    f0 = falls_a;
    repeat (2 * INTV - 1) @(negedge clk);
    chk(!a_ovf, "R10 two pending without overflow", a_ovf, 0);
    chk(falls_a == f0 && a_gnt, "R11 no refresh while granted", falls_a - f0, 0);
    repeat (INTV) @(negedge clk);
    chk(a_ovf, "R10 third expiry overflows", a_ovf, 1);
    acc_req = 1'b0;
    @(negedge clk);
    chk(!a_gnt, "R11 grant drops after release", a_gnt, 0);
    acc_req = 1'b1;
    g = 0;
    while (!a_gnt && g < 200) begin
      @(negedge clk);
      g++;
    end
    chk(falls_a - f0 == 2, "R10 pending refreshes served before grant", falls_a - f0, 2);
    chk(a_gnt, "R11 grant after refreshes", a_gnt, 1);
    acc_req = 1'b0;
    @(negedge clk);
    chk(!a_gnt, "R11 grant released", a_gnt, 0);
    chk(a_ovf, "R10 overflow sticky", a_ovf, 1);
    chk(falls_b >= 10, "R8 row counter wrapped", falls_b, 10);
    chk(b_init, "R3 row copy initialized", b_init, 1);
    finish_run();
  end
endmodule